// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This block forms the 32-bit memory address named by an instruction's addressing byte and, when that byte asks for it, by the scaled-index byte that follows. It reads a flat view of the eight general registers, picks a base and an index register, shifts the index left by the scale, adds a displacement and registers the sum. The design captures a request in the cycle its valid strobe is high and presents the address one clock later, together with a valid flag.

The block also detects register-direct operands. For these it raises a flag and returns the register number in place of an address. It has a single displacement input of 32 bits. When the mode calls for a byte displacement, only the low byte of that input is used, and it is sign-extended. Segment bases, 16-bit addressing, operand byte fetch and address translation are not part of this block.

Top module: `ea_gen`

## Requirements
- R1: While rst_ni is low, ea_valid_o, reg_direct_o, reg_sel_o and ea_o are all zero.
- R2: ea_valid_o is high in exactly those cycles that follow a cycle with req_valid_i high. Back-to-back requests each give their own result.
- R3: Mode bits modrm_i[7:6] = 3 give a register-direct result: reg_direct_o = 1, reg_sel_o = modrm_i[2:0] and ea_o = 0. For memory forms reg_direct_o = 0.
- R4: With mode 0 and an r/m field modrm_i[2:0] other than 4 or 5, the address is the register selected by r/m. Register n occupies gpr_i[32n+31:32n].
- R5: With mode 0 and r/m = 5, the address is disp_i alone, and no register contributes.
- R6: With mode 1 and r/m not equal to 4, the address is the r/m register plus disp_i[7:0] sign-extended. disp_i[31:8] is ignored.
- R7: With mode 2 and r/m not equal to 4, the address is the r/m register plus the full disp_i.
- R8: An r/m field of 4 selects the scaled-index byte sib_i. Its fields are scale in [7:6], index in [5:3] and base in [2:0]. The address is base + (index << scale), so scale codes 0 to 3 multiply the index by 1, 2, 4 or 8. Modes 1 and 2 add the displacement as in R6 and R7.
- R9: An index field of 4 contributes nothing to the address, whatever the scale.
- R10: With mode 0 and a scaled-index base of 5, the address is disp_i + (index << scale) and no base register is used. In modes 1 and 2, a base of 5 selects register 5.
- R11: All additions wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe; captures the inputs on this edge |
| modrm_i | input | 8 | Addressing byte: mode [7:6], reg [5:3], r/m [2:0] |
| sib_i | input | 8 | Scaled-index byte: scale [7:6], index [5:3], base [2:0] |
| disp_i | input | 32 | Displacement; low byte only for byte forms |
| gpr_i | input | 256 | Eight 32-bit registers; register n at bits 32n+31:32n |
| ea_valid_o | output | 1 | Result valid, one cycle after the request |
| ea_o | output | 32 | Effective address; zero for register-direct |
| reg_direct_o | output | 1 | Register-direct operand, no memory address |
| reg_sel_o | output | 3 | Register number for register-direct operands |

## Verification
The bench targets the encodings in which a register number means something other than a register. Three cases get their own tests: r/m 5 in mode 0, base 5 in mode 0, and index 4. A design that missed one of them would add register 5 or register 4 into the address, and every test register holds a distinct nonzero value, so the address would come out wrong. Each scale code is checked on its own, which catches a scale field that is misread or reversed. A byte displacement with bit 7 set and unrelated upper bits catches a missing sign extension and an unmasked upper displacement. A base of 5 in mode 1 catches a design that applies the no-base rule in every mode.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int unsigned SEL_W    = 3;
  localparam int unsigned NUM_REGS = 1 << SEL_W;

  localparam logic [1:0]       MOD_NODISP = 2'b00;
  localparam logic [1:0]       MOD_DISP8  = 2'b01;
  localparam logic [1:0]       MOD_DISP32 = 2'b10;
  localparam logic [1:0]       MOD_REG    = 2'b11;
  localparam logic [SEL_W-1:0] RM_SIB     = 3'd4;
  localparam logic [SEL_W-1:0] RM_ABS     = 3'd5;
  localparam logic [SEL_W-1:0] IDX_NONE   = 3'd4;
  localparam logic [SEL_W-1:0] BASE_NONE  = 3'd5;

  typedef enum logic [1:0] {
    DISP_NONE = 2'd0,
    DISP_BYTE = 2'd1,
    DISP_WORD = 2'd2
  } disp_kind_e;

  typedef struct packed {
    logic             reg_direct;
    logic [SEL_W-1:0] reg_sel;
    logic             base_en;
    logic [SEL_W-1:0] base_sel;
    logic             index_en;
    logic [SEL_W-1:0] index_sel;
    logic [1:0]       scale;
    disp_kind_e       disp_kind;
  } ea_ctrl_t;
endpackage

// File: rtl/ea_decode.sv
module ea_decode
  import ea_pkg::*;
(
  input  logic [7:0] modrm_i,
  input  logic [7:0] sib_i,
  output ea_ctrl_t   ctrl_o
);
  logic [1:0]       mode;
  logic [SEL_W-1:0] rm;
  logic [SEL_W-1:0] sib_base;
  logic [SEL_W-1:0] sib_index;

  assign mode      = modrm_i[7:6];
  assign rm        = modrm_i[2:0];
  assign sib_base  = sib_i[2:0];
  assign sib_index = sib_i[5:3];

  always_comb begin
    ctrl_o           = '0;
    ctrl_o.disp_kind = DISP_NONE;
    if (mode == MOD_REG) begin
      ctrl_o.reg_direct = 1'b1;
      ctrl_o.reg_sel    = rm;
    end else begin
      case (mode)
        MOD_DISP8:  ctrl_o.disp_kind = DISP_BYTE;
        MOD_DISP32: ctrl_o.disp_kind = DISP_WORD;
        default:    ctrl_o.disp_kind = DISP_NONE;
      endcase
      if (rm == RM_SIB) begin
        ctrl_o.index_en  = (sib_index != IDX_NONE);
        ctrl_o.index_sel = sib_index;
        ctrl_o.scale     = sib_i[7:6];
        ctrl_o.base_sel  = sib_base;
        // mode 0 base 5: displacement replaces the base register
        if (mode == MOD_NODISP && sib_base == BASE_NONE) begin
          ctrl_o.base_en   = 1'b0;
          ctrl_o.disp_kind = DISP_WORD;
        end else begin
          ctrl_o.base_en = 1'b1;
        end
      end else if (mode == MOD_NODISP && rm == RM_ABS) begin
        ctrl_o.disp_kind = DISP_WORD;
      end else begin
        ctrl_o.base_en  = 1'b1;
        ctrl_o.base_sel = rm;
      end
    end
  end
endmodule

// File: rtl/ea_operands.sv
module ea_operands
  import ea_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned DISP8_W = 8
) (
  input  ea_ctrl_t                ctrl_i,
  input  logic [NUM_REGS*XLEN-1:0] gpr_i,
  input  logic [XLEN-1:0]         disp_i,
  output logic [XLEN-1:0]         base_o,
  output logic [XLEN-1:0]         index_o,
  output logic [XLEN-1:0]         disp_o
);
  logic [XLEN-1:0] regs [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_unpack
    assign regs[g] = gpr_i[g*XLEN +: XLEN];
  end

  assign base_o  = ctrl_i.base_en  ? regs[ctrl_i.base_sel] : '0;
  assign index_o = ctrl_i.index_en ? (regs[ctrl_i.index_sel] << ctrl_i.scale) : '0;

  always_comb begin
    case (ctrl_i.disp_kind)
      DISP_BYTE: disp_o = {{(XLEN-DISP8_W){disp_i[DISP8_W-1]}}, disp_i[DISP8_W-1:0]};
      DISP_WORD: disp_o = disp_i;
      default:   disp_o = '0;
    endcase
  end
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned DISP8_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_valid_i,
  input  logic [7:0]               modrm_i,
  input  logic [7:0]               sib_i,
  input  logic [XLEN-1:0]          disp_i,
  input  logic [NUM_REGS*XLEN-1:0] gpr_i,
  output logic                     ea_valid_o,
  output logic [XLEN-1:0]          ea_o,
  output logic                     reg_direct_o,
  output logic [SEL_W-1:0]         reg_sel_o
);
  ea_ctrl_t        ctrl;
  logic [XLEN-1:0] base_term;
  logic [XLEN-1:0] index_term;
  logic [XLEN-1:0] disp_term;
  logic [XLEN-1:0] sum;

  ea_decode i_decode (
    .modrm_i (modrm_i),
    .sib_i   (sib_i),
    .ctrl_o  (ctrl)
  );

  ea_operands #(.XLEN(XLEN), .DISP8_W(DISP8_W)) i_operands (
    .ctrl_i  (ctrl),
    .gpr_i   (gpr_i),
    .disp_i  (disp_i),
    .base_o  (base_term),
    .index_o (index_term),
    .disp_o  (disp_term)
  );

  // wraps modulo 2^XLEN
  assign sum = base_term + index_term + disp_term;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ea_valid_o   <= 1'b0;
      ea_o         <= '0;
      reg_direct_o <= 1'b0;
      reg_sel_o    <= '0;
    end else begin
      ea_valid_o <= req_valid_i;
      if (req_valid_i) begin
        ea_o         <= ctrl.reg_direct ? '0 : sum;
        reg_direct_o <= ctrl.reg_direct;
        reg_sel_o    <= ctrl.reg_direct ? ctrl.reg_sel : '0;
      end
    end
  end
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk
  import ea_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     req_valid_i,
  input logic [7:0]               modrm_i,
  input logic [7:0]               sib_i,
  input logic [XLEN-1:0]          disp_i,
  input logic [NUM_REGS*XLEN-1:0] gpr_i,
  input logic                     ea_valid_o,
  input logic [XLEN-1:0]          ea_o,
  input logic                     reg_direct_o,
  input logic [SEL_W-1:0]         reg_sel_o
);
  logic [XLEN-1:0] sib_base_val;
  logic            mem_form;
  logic            abs_form;
  logic            no_index_form;

  assign sib_base_val  = gpr_i[sib_i[2:0]*XLEN +: XLEN];
  assign mem_form      = req_valid_i && (modrm_i[7:6] != 2'b11);
  assign abs_form      = req_valid_i && (modrm_i[7:6] == 2'b00) && (modrm_i[2:0] == 3'd5);
  assign no_index_form = req_valid_i && (modrm_i[7:6] == 2'b00) && (modrm_i[2:0] == 3'd4)
                         && (sib_i[5:3] == 3'd4) && (sib_i[2:0] != 3'd5);

  assert_valid_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> ea_valid_o);
  assert_valid_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !ea_valid_o);
  assert_direct_sel_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && modrm_i[7:6] == 2'b11) |=>
      (reg_direct_o && reg_sel_o == $past(modrm_i[2:0]) && ea_o == '0));
  assert_mem_not_direct_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_form |=> !reg_direct_o);
  assert_abs_disp_only_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abs_form |=> (ea_o == $past(disp_i)));
  assert_no_index_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    no_index_form |=> (ea_o == $past(sib_base_val)));
endmodule

bind ea_gen ea_gen_chk #(.XLEN(XLEN)) i_ea_gen_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .modrm_i      (modrm_i),
  .sib_i        (sib_i),
  .disp_i       (disp_i),
  .gpr_i        (gpr_i),
  .ea_valid_o   (ea_valid_o),
  .ea_o         (ea_o),
  .reg_direct_o (reg_direct_o),
  .reg_sel_o    (reg_sel_o)
);

// File: tb/test_ea_gen.sv
module test_ea_gen;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         req_valid_i = 1'b0;
  logic [7:0]   modrm_i = '0;
  logic [7:0]   sib_i = '0;
  logic [31:0]  disp_i = '0;
  logic [255:0] gpr_i;
  logic         ea_valid_o;
  logic [31:0]  ea_o;
  logic         reg_direct_o;
  logic [2:0]   reg_sel_o;

  logic [31:0]  regs [8];
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk_i = ~clk_i;

  always_comb
    for (int i = 0; i < 8; i++) gpr_i[i*32 +: 32] = regs[i];

  ea_gen i_ea_gen (
    .clk_i, .rst_ni, .req_valid_i, .modrm_i, .sib_i, .disp_i, .gpr_i,
    .ea_valid_o, .ea_o, .reg_direct_o, .reg_sel_o
  );

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog expired got %0d cycles exp done", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  // one-cycle request, outputs sampled at the following negedge
  task automatic issue(logic [7:0] m, logic [7:0] s, logic [31:0] d);
    @(negedge clk_i);
    modrm_i = m; sib_i = s; disp_i = d; req_valid_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  task automatic mem_case(string req, logic [7:0] m, logic [7:0] s, logic [31:0] d,
                          logic [31:0] exp);
    issue(m, s, d);
    chk(req, {31'b0, ea_valid_o}, 32'd1);
    chk(req, {31'b0, reg_direct_o}, 32'd0);
    chk(req, ea_o, exp);
  endtask

  task automatic t_reset;
    #1;
    chk("R1 valid", {31'b0, ea_valid_o}, 32'd0);
    chk("R1 ea", ea_o, 32'd0);
    chk("R1 direct", {28'b0, reg_direct_o, reg_sel_o}, 32'd0);
  endtask

  task automatic t_latency;
    issue(8'h03, 8'h00, 32'h0);
    @(negedge clk_i);
    chk("R2 idle valid low", {31'b0, ea_valid_o}, 32'd0);
    // back-to-back
    @(negedge clk_i);
    modrm_i = 8'h01; req_valid_i = 1'b1;
    @(negedge clk_i);
    chk("R2 b2b first", ea_o, regs[1]);
    modrm_i = 8'h07;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk("R2 b2b second valid", {31'b0, ea_valid_o}, 32'd1);
    chk("R2 b2b second", ea_o, regs[7]);
  endtask

  task automatic t_direct;
    issue({2'b11, 3'b010, 3'b110}, 8'hFF, 32'hFFFF_FFFF);
    chk("R3 direct flag", {31'b0, reg_direct_o}, 32'd1);
    chk("R3 reg sel", {29'b0, reg_sel_o}, 32'd6);
    chk("R3 ea zero", ea_o, 32'd0);
  endtask

  task automatic t_mode0;
    mem_case("R4 mode0 rm3", {2'b00, 3'b000, 3'b011}, 8'hFF, 32'h5555_5555, regs[3]);
    mem_case("R4 mode0 rm6", {2'b00, 3'b111, 3'b110}, 8'h00, 32'h0, regs[6]);
    mem_case("R5 absolute", {2'b00, 3'b000, 3'b101}, 8'hFF, 32'hDEAD_BEEF, 32'hDEAD_BEEF);
  endtask

  task automatic t_disp;
    mem_case("R6 byte disp neg", {2'b01, 3'b000, 3'b101}, 8'h00, 32'h1234_5680,
             regs[5] - 32'd128);
    mem_case("R6 byte disp pos", {2'b01, 3'b000, 3'b000}, 8'h00, 32'hFFFF_FF7F,
             regs[0] + 32'd127);
    mem_case("R7 word disp", {2'b10, 3'b000, 3'b001}, 8'h00, 32'h0010_0000,
             regs[1] + 32'h0010_0000);
  endtask

  task automatic t_scale;
    for (int ss = 0; ss < 4; ss++)
      mem_case("R8 scale", {2'b00, 3'b000, 3'b100}, {ss[1:0], 3'b001, 3'b011}, 32'h0,
               regs[3] + (regs[1] << ss));
    mem_case("R8 mode2 sib", {2'b10, 3'b000, 3'b100}, {2'b01, 3'b111, 3'b000},
             32'h0000_1000, regs[0] + (regs[7] << 1) + 32'h1000);
  endtask

  task automatic t_no_index;
    mem_case("R9 index4", {2'b00, 3'b000, 3'b100}, {2'b11, 3'b100, 3'b010}, 32'h0, regs[2]);
    mem_case("R9 index4 mode1", {2'b01, 3'b000, 3'b100}, {2'b10, 3'b100, 3'b110}, 32'h0000_0010,
             regs[6] + 32'h10);
  endtask

  task automatic t_no_base;
    mem_case("R10 mode0 base5", {2'b00, 3'b000, 3'b100}, {2'b10, 3'b110, 3'b101},
             32'h0800_0000, 32'h0800_0000 + (regs[6] << 2));
    mem_case("R10 mode1 base5 is reg", {2'b01, 3'b000, 3'b100}, {2'b00, 3'b010, 3'b101},
             32'h0000_00F0, regs[5] + regs[2] - 32'h10);
    mem_case("R10 base5 index4", {2'b00, 3'b000, 3'b100}, {2'b00, 3'b100, 3'b101},
             32'h0000_4000, 32'h0000_4000);
  endtask

  task automatic t_wrap;
    regs[0] = 32'hFFFF_FFF0;
    mem_case("R11 wrap", {2'b10, 3'b000, 3'b000}, 8'h00, 32'h0000_0020, 32'h0000_0010);
    regs[4] = 32'h8000_0001;
    mem_case("R11 wrap scaled", {2'b00, 3'b000, 3'b100}, {2'b11, 3'b001, 3'b100}, 32'h0,
             32'h8000_0001 + (regs[1] << 3));
  endtask

  initial begin
    for (int i = 0; i < 8; i++) regs[i] = 32'h0100_0000 * (i + 1) + 32'h10 * i + 32'h3;
    t_reset();
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_latency();
    t_direct();
    t_mode0();
    t_disp();
    t_scale();
    t_no_index();
    t_no_base();
    t_wrap();
    @(negedge clk_i);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule